// File: doc/BRIEF.md
# Descriptor-Table Scatter-Gather DMA Engine

This block moves the contents of a local sector buffer to or from host memory by following a table of region descriptors that lives in host memory. Each descriptor is 8 bytes long and little-endian. The low 32-bit word gives the base address of a region. The high word gives the region's byte count in its low 16 bits and an end-of-table flag in bit 31. The engine reads one descriptor at a time through a 64-bit read port. It then issues chunk commands to a separate move port. Each command carries a host address, a length, an offset into the local buffer and a direction.

A controller starts a pass with `go`, giving the number of buffer bytes to move. `go_first` marks the first pass of a transfer. On such a pass the table pointer is reloaded from the programmed base and any leftover region is dropped. On later passes the engine resumes inside the region where the previous pass stopped. A pass ends with a one-cycle `done` pulse. `tbl_end` then shows whether the pass ran out of table before the buffer was emptied.

The table walk stops at the descriptor flagged as last. As a safety limit, it also stops once the table pointer is a full page (4096 bytes) or more past the table base.

Top module: `sgdma_engine`

## Requirements
- R1: After reset, `fetch_valid`, `mv_valid`, `done` and `tbl_end` are all 0.
- R2: On a pass started with `go_first`=1, the first descriptor read goes to `tbl_base` with its two low bits forced to 0. Each later descriptor read is 8 bytes above the previous one.
- R3: A descriptor's bits [31:0] are the region address. Its byte count is bits [47:32] with bit 32 forced to 0. Bit 63 marks the last descriptor, and bits [62:48] are ignored.
- R4: A masked byte count of zero means a region of 65536 bytes.
- R5: A descriptor is read only when the current region has no bytes left.
- R6: Each chunk length is the smaller of the bytes left in the buffer pass and the bytes left in the region. After each chunk:
  - the chunk address and buffer offset advance by the chunk length;
  - the region's remaining length shrinks by it.
- R7: When the region is empty and the last-descriptor flag has been seen while buffer bytes remain, the pass ends with `done` and `tbl_end`=1. No further descriptor is read.
- R8: When the table pointer is 4096 or more bytes past the base and the region is empty, the pass ends with `tbl_end`=1 and no further descriptor is read.
- R9: When the buffer bytes of a pass reach zero, the pass ends with `done` and `tbl_end`=0. A following pass with `go_first`=0 resumes in the same region at the next address.
- R10: `mv_to_host` carries the `to_host` value that was sampled with `go` (1 = buffer to host memory, 0 = host memory to buffer).
- R11: A request on either port holds its valid signal and its fields stable until `ready` is seen. The two ports never request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a pass (accepted when idle) |
| go_first | input | 1 | With `go`: reload table pointer, drop current region |
| to_host | input | 1 | With `go`: 1 = buffer to memory, 0 = memory to buffer |
| tbl_base | input | 32 | Table base address |
| buf_len | input | 17 | With `go`: buffer bytes to move in this pass |
| done | output | 1 | One-cycle end-of-pass pulse |
| tbl_end | output | 1 | Pass ended because the table was exhausted |
| fetch_valid | output | 1 | Descriptor read request |
| fetch_ready | input | 1 | Descriptor read accepted |
| fetch_addr | output | 32 | Descriptor address |
| fetch_rvalid | input | 1 | Descriptor data valid |
| fetch_rdata | input | 64 | Descriptor data, little-endian |
| mv_valid | output | 1 | Chunk move request |
| mv_ready | input | 1 | Chunk move accepted |
| mv_addr | output | 32 | Host address of chunk |
| mv_len | output | 17 | Chunk length in bytes |
| mv_buf_off | output | 17 | Offset of chunk in local buffer |
| mv_to_host | output | 1 | Chunk direction |

## Verification
The assertions check on every cycle that:
- requests on both ports stay stable while stalled;
- the two ports never request together;
- a descriptor is never read while a region still holds bytes, or after the last flag;
- no descriptor read falls outside the one-page window.

Only the bench scenarios can show the chunk lengths and offsets, the masking and zero-count decoding of descriptors, and resumption across passes. They also show the choice between buffer-done and table-end. Each of these depends on descriptor contents that the bench supplies.

// File: rtl/sgdma_pkg.sv
// Shared widths and state encoding for the scatter-gather DMA engine.
// Assumes descriptor counts of 16 bits and 32-bit host addresses.
package sgdma_pkg;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 16;
    localparam int LEN_W      = CNT_W + 1;
    localparam int DESC_W     = 64;
    localparam int DESC_BYTES = DESC_W / 8;
    localparam int PAGE_BYTES = 4096;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FREQ,
        ST_FWAIT,
        ST_MOVE,
        ST_DONE
    } walk_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
    } region_t;
endpackage

// File: rtl/sgdma_desc_decode.sv
// Decodes one 64-bit little-endian descriptor into a region record.
// Assumes the caller presents the two words in memory order.
// Odd counts lose bit 0; a zero count stands for the full 2^CNT_W bytes.
module sgdma_desc_decode
    import sgdma_pkg::*;
(
    input  logic [DESC_W-1:0] raw,
    output region_t           region
);
    logic [CNT_W-1:0] cnt_even;

    // Mask the count even and expand zero to the full size
    always_comb begin
        cnt_even      = {raw[ADDR_W+CNT_W-1:ADDR_W+1], 1'b0};
        region.addr   = raw[ADDR_W-1:0];
        region.last   = raw[DESC_W-1];
        if (cnt_even == '0)
            region.len = LEN_W'(1) << CNT_W;
        else
            region.len = {1'b0, cnt_even};
    end
endmodule

// File: rtl/sgdma_chunk_size.sv
// Picks the chunk length: the smaller of buffer bytes left and region bytes left.
// Assumes both inputs share one width.
module sgdma_chunk_size #(
    parameter int W = 17
) (
    input  logic [W-1:0] buf_left,
    input  logic [W-1:0] reg_left,
    output logic [W-1:0] chunk
);
    // Minimum of the two remaining counts
    always_comb chunk = (buf_left < reg_left) ? buf_left : reg_left;
endmodule

// File: rtl/sgdma_walker.sv
// Control and bookkeeping for the table walk: table pointer, current
// region, buffer progress, and the end-of-pass decision.
// Assumes the decoded descriptor and chunk length come from outside.
// The memory returns descriptor data at least one cycle after accept.
module sgdma_walker
    import sgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_first,
    input  logic              to_host,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LEN_W-1:0]  buf_len,
    input  region_t           dec,
    input  logic [LEN_W-1:0]  chunk_len,
    output logic [LEN_W-1:0]  buf_left,
    output logic [LEN_W-1:0]  reg_left,
    output logic              done,
    output logic              tbl_end,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_rvalid,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    output logic [LEN_W-1:0]  mv_buf_off,
    output logic              mv_to_host
);
    walk_state_t       state;
    logic [ADDR_W-1:0] base_q, ptr_q, raddr_q;
    logic [LEN_W-1:0]  rlen_q, rem_q, idx_q;
    logic              last_q, dir_q, end_q;
    logic              page_out;

    // Safety limit: table pointer a full page or more past the base
    always_comb page_out = (ptr_q - base_q) >= ADDR_W'(PAGE_BYTES);

    // Walk state machine with region and buffer bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            ptr_q   <= '0;
            raddr_q <= '0;
            rlen_q  <= '0;
            rem_q   <= '0;
            idx_q   <= '0;
            last_q  <= 1'b0;
            dir_q   <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    if (go_first) begin
                        base_q <= {tbl_base[ADDR_W-1:2], 2'b00};
                        ptr_q  <= {tbl_base[ADDR_W-1:2], 2'b00};
                        rlen_q <= '0;
                        last_q <= 1'b0;
                    end
                    rem_q <= buf_len;
                    idx_q <= '0;
                    dir_q <= to_host;
                    end_q <= 1'b0;
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (rem_q == '0) begin
                        end_q <= 1'b0;
                        state <= ST_DONE;
                    end else if (rlen_q == '0) begin
                        if (last_q || page_out) begin
                            end_q <= 1'b1;
                            state <= ST_DONE;
                        end else begin
                            state <= ST_FREQ;
                        end
                    end else begin
                        state <= ST_MOVE;
                    end
                end
                ST_FREQ: if (fetch_ready) state <= ST_FWAIT;
                ST_FWAIT: if (fetch_rvalid) begin
                    raddr_q <= dec.addr;
                    rlen_q  <= dec.len;
                    last_q  <= dec.last;
                    ptr_q   <= ptr_q + ADDR_W'(DESC_BYTES);
                    state   <= ST_CHECK;
                end
                ST_MOVE: if (mv_ready) begin
                    raddr_q <= raddr_q + ADDR_W'(chunk_len);
                    rlen_q  <= rlen_q - chunk_len;
                    rem_q   <= rem_q - chunk_len;
                    idx_q   <= idx_q + chunk_len;
                    state   <= ST_CHECK;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port drives taken from state and registers
    always_comb begin
        buf_left    = rem_q;
        reg_left    = rlen_q;
        done        = (state == ST_DONE);
        tbl_end     = end_q;
        fetch_valid = (state == ST_FREQ);
        fetch_addr  = ptr_q;
        mv_valid    = (state == ST_MOVE);
        mv_addr     = raddr_q;
        mv_len      = chunk_len;
        mv_buf_off  = idx_q;
        mv_to_host  = dir_q;
    end

    // R11: descriptor request held until accepted
    a_r11_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_addr));
    // R11: chunk request held until accepted
    a_r11_move_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid && !mv_ready |=> mv_valid && $stable(mv_addr)
                                  && $stable(mv_len) && $stable(mv_buf_off));
    // R11: never both ports at once
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_valid && mv_valid));
    // R5: fetch only with an empty region
    a_r5_fetch_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> rlen_q == '0);
    // R7: no fetch once the last descriptor is loaded
    a_r7_no_fetch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> !last_q);
    // R8: every fetch lies inside the one-page window
    a_r8_page_window: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_addr - base_q) < ADDR_W'(PAGE_BYTES));
    // R6: an accepted chunk is non-empty and fits both budgets
    a_r6_chunk_fits: assert property (@(posedge clk) disable iff (!rst_n)
        mv_valid |-> mv_len != '0 && mv_len <= rem_q && mv_len <= rlen_q);
endmodule

// File: rtl/sgdma_engine.sv
// Top of the scatter-gather DMA engine: joins the descriptor decoder,
// the chunk sizer and the walk controller.
// Assumes one outstanding request at a time on each memory port.
module sgdma_engine
    import sgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              go_first,
    input  logic              to_host,
    input  logic [31:0]       tbl_base,
    input  logic [16:0]       buf_len,
    output logic              done,
    output logic              tbl_end,
    output logic              fetch_valid,
    input  logic              fetch_ready,
    output logic [31:0]       fetch_addr,
    input  logic              fetch_rvalid,
    input  logic [63:0]       fetch_rdata,
    output logic              mv_valid,
    input  logic              mv_ready,
    output logic [31:0]       mv_addr,
    output logic [16:0]       mv_len,
    output logic [16:0]       mv_buf_off,
    output logic              mv_to_host
);
    region_t          dec;
    logic [LEN_W-1:0] chunk_len, buf_left, reg_left;

    sgdma_desc_decode u_dec (
        .raw    (fetch_rdata),
        .region (dec)
    );

    sgdma_chunk_size #(.W(LEN_W)) u_chunk (
        .buf_left (buf_left),
        .reg_left (reg_left),
        .chunk    (chunk_len)
    );

    sgdma_walker u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .go_first     (go_first),
        .to_host      (to_host),
        .tbl_base     (tbl_base),
        .buf_len      (buf_len),
        .dec          (dec),
        .chunk_len    (chunk_len),
        .buf_left     (buf_left),
        .reg_left     (reg_left),
        .done         (done),
        .tbl_end      (tbl_end),
        .fetch_valid  (fetch_valid),
        .fetch_ready  (fetch_ready),
        .fetch_addr   (fetch_addr),
        .fetch_rvalid (fetch_rvalid),
        .mv_valid     (mv_valid),
        .mv_ready     (mv_ready),
        .mv_addr      (mv_addr),
        .mv_len       (mv_len),
        .mv_buf_off   (mv_buf_off),
        .mv_to_host   (mv_to_host)
    );
endmodule

// File: tb/sgdma_engine_test.sv
module sgdma_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    // {size word, buffer bytes, expected first chunk, expected tbl_end}
    localparam logic [66:0] VEC [6] = '{
        {32'h8000_0100, 17'h00040, 17'h00040, 1'b0},
        {32'h8000_0100, 17'h00100, 17'h00100, 1'b0},
        {32'h8000_0101, 17'h00200, 17'h00100, 1'b1},
        {32'h8000_0000, 17'h10000, 17'h10000, 1'b0},
        {32'h8000_FFFF, 17'h10000, 17'h0FFFE, 1'b1},
        {32'h8003_0010, 17'h00020, 17'h00010, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic go = 1'b0, go_first = 1'b0, to_host = 1'b0;
    logic [31:0] tbl_base = '0;
    logic [16:0] buf_len = '0;
    logic done, tbl_end, fetch_valid, fetch_ready, fetch_rvalid;
    logic mv_valid, mv_ready, mv_to_host;
    logic [31:0] fetch_addr, mv_addr;
    logic [63:0] fetch_rdata;
    logic [16:0] mv_len, mv_buf_off;

    int checks = 0, errors = 0, cycles = 0;
    int stall = 0;
    logic page_mode = 1'b0, clr = 1'b0;
    logic [31:0] mem_base = '0;
    logic [63:0] tbl [8];
    int f_cnt = 0, m_cnt = 0;
    int n_fetch, n_chunk, sum_bytes;
    logic [31:0] first_faddr, last_faddr;
    logic [31:0] l_addr [8];
    logic [16:0] l_len [8], l_off [8];
    logic        l_dir [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    sgdma_engine uut (.*);

    assign fetch_ready = fetch_valid && (f_cnt >= stall);
    assign mv_ready    = mv_valid && (m_cnt >= stall);

    function automatic logic [63:0] desc_at(input logic [31:0] a);
        logic [31:0] off = a - mem_base;
        if (page_mode)
            return {32'h0000_0002, 32'h3000_0000 + (off << 5)};
        return tbl[off[5:3]];
    endfunction

    // Memory model: stalls, descriptor reply and logging
    always_ff @(posedge clk) begin
        f_cnt <= (fetch_valid && !fetch_ready) ? f_cnt + 1 : 0;
        m_cnt <= (mv_valid && !mv_ready) ? m_cnt + 1 : 0;
        fetch_rvalid <= fetch_valid && fetch_ready;
        fetch_rdata  <= desc_at(fetch_addr);
        if (clr) begin
            n_fetch <= 0; n_chunk <= 0; sum_bytes <= 0;
        end else begin
            if (fetch_valid && fetch_ready) begin
                if (n_fetch == 0) first_faddr <= fetch_addr;
                last_faddr <= fetch_addr;
                n_fetch <= n_fetch + 1;
            end
            if (mv_valid && mv_ready) begin
                if (n_chunk < 8) begin
                    l_addr[n_chunk] <= mv_addr;
                    l_len[n_chunk]  <= mv_len;
                    l_off[n_chunk]  <= mv_buf_off;
                    l_dir[n_chunk]  <= mv_to_host;
                end
                n_chunk   <= n_chunk + 1;
                sum_bytes <= sum_bytes + int'(mv_len);
            end
        end
    end

    task automatic check(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_pass(input logic first, input logic dir, input logic [31:0] base,
                            input logic [16:0] len);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        go = 1'b1; go_first = first; to_host = dir; tbl_base = base; buf_len = len;
        @(negedge clk);
        go = 1'b0;
        while (!done && cycles < WATCHDOG) begin
            @(negedge clk);
            cycles++;
        end
        if (!done) check(1'b0, "watchdog", 0, 1);
    endtask

    initial begin
        foreach (tbl[i]) tbl[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!fetch_valid && !mv_valid && !done && !tbl_end, "R1",
              {fetch_valid, mv_valid, done, tbl_end}, 0);
        rst_n = 1'b1;

        // Vector table: one last descriptor, chunk sizing and decode (R3 R4 R6 R7 R9)
        for (int v = 0; v < 6; v++) begin
            mem_base = 32'h1000;
            tbl[0] = {VEC[v][66:35], 32'h1000_0000};
            run_pass(1'b1, 1'b1, 32'h1000, VEC[v][34:18]);
            check(l_len[0] == VEC[v][17:1], "R6 first chunk", l_len[0], VEC[v][17:1]);
            check(l_addr[0] == 32'h1000_0000, "R3 region addr", l_addr[0], 32'h1000_0000);
            check(tbl_end == VEC[v][0], "R7/R9 end flag", tbl_end, VEC[v][0]);
            check(n_fetch == 1, "R5 one fetch", n_fetch, 1);
        end

        // Two descriptors with stalls, then resume (R2 R5 R6 R9 R10 R11)
        stall = 2;
        mem_base = 32'h4000;
        tbl[0] = {32'h0000_0020, 32'hA000_0000};
        tbl[1] = {32'h8000_0010, 32'hB000_0000};
        run_pass(1'b1, 1'b1, 32'h4000, 17'h28);
        check(n_chunk == 2, "R6 chunk count", n_chunk, 2);
        check(l_addr[1] == 32'hB000_0000 && l_len[1] == 17'h8 && l_off[1] == 17'h20,
              "R6 second chunk", {l_addr[1], l_len[1]}, {32'hB000_0000, 17'h8});
        check(first_faddr == 32'h4000 && last_faddr == 32'h4008, "R2 fetch addrs",
              last_faddr, 32'h4008);
        check(l_dir[0] && l_dir[1], "R10 to host", l_dir[0], 1);
        check(!tbl_end, "R9 buffer done", tbl_end, 0);
        run_pass(1'b0, 1'b0, 32'h4000, 17'h10);
        check(n_fetch == 0, "R9 no refetch on resume", n_fetch, 0);
        check(l_addr[0] == 32'hB000_0008 && l_len[0] == 17'h8 && l_off[0] == 17'h0,
              "R9 resume point", l_addr[0], 32'hB000_0008);
        check(!l_dir[0], "R10 from host", l_dir[0], 0);
        check(tbl_end && n_chunk == 1, "R7 last flag ends table", tbl_end, 1);
        stall = 0;

        // Unaligned base (R2)
        mem_base = 32'h5000;
        tbl[0] = {32'h8000_0004, 32'hC000_0000};
        run_pass(1'b1, 1'b1, 32'h5003, 17'h4);
        check(first_faddr == 32'h5000, "R2 aligned base", first_faddr, 32'h5000);

        // Page safety limit (R8)
        page_mode = 1'b1;
        mem_base = 32'h6000;
        run_pass(1'b1, 1'b0, 32'h6000, 17'h1000);
        check(n_fetch == 512, "R8 fetch count", n_fetch, 512);
        check(last_faddr == 32'h6FF8, "R8 last fetch addr", last_faddr, 32'h6FF8);
        check(sum_bytes == 1024, "R8 bytes moved", sum_bytes, 1024);
        check(tbl_end, "R8 page end flag", tbl_end, 1);
        page_mode = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule